// File: doc/BRIEF.md
# Cascade Partial-Sum Combiner

This block sits at the output of one stage in a chain of convolution stages. Each cycle it may take a sum computed locally and a partial sum handed on by the stage upstream. It adds the two at a fixed 32-bit internal precision and registers the result for the next stage or for the final gain logic.

To handle pixels wider than eight bits, the work is split across two stages. One stage computes the contribution of the pixel's low byte and passes it downstream. The other stage computes the contribution of the high byte. A control input multiplies that local high-part sum by 256 before the addition, so the two halves merge exactly.

A second control input selects a restricted hand-off. In that mode only the low 16 bits of the upstream sum are meaningful. A sticky flag records whether any accepted restricted-mode result fell outside the signed 16-bit range.

Top module: `cps_cascade_add`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, res is 0, res_vld is 0 and narrow_ovf is 0.
- R2: When loc_vld and exp_vld are both 1 at a rising clock edge with shift_en 0 and narrow_mode 0, res becomes loc_sum + exp_sum after that edge, and res_vld is 1 for that cycle.
- R3: With shift_en 1, the local sum is shifted left by eight places (times 256) before the addition. Bits shifted past bit 31 are lost, and res[7:0] equals exp_sum[7:0].
- R4: With narrow_mode 1, exp_sum[31:16] is ignored and exp_sum[15:0] is sign-extended from bit 15 to 32 bits before the addition.
- R5: The addition wraps modulo 2^32, with no saturation.
- R6: In a cycle where loc_vld and exp_vld are not both 1, res keeps its value and res_vld is 0 on the following cycle.
- R7: When an accepted result in narrow_mode 1 lies outside the signed range -32768..32767, narrow_ovf becomes 1 on the same edge that loads res. It then stays 1 until reset.
- R8: Results accepted with narrow_mode 0, and inputs that are not accepted, never set narrow_ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_sum | input | 32 | Locally computed convolution sum, two's complement |
| loc_vld | input | 1 | loc_sum is valid this cycle |
| exp_sum | input | 32 | Partial sum from the upstream stage, two's complement |
| exp_vld | input | 1 | exp_sum is valid this cycle |
| shift_en | input | 1 | Multiply the local sum by 256 before adding |
| narrow_mode | input | 1 | Only exp_sum[15:0] is meaningful (restricted hand-off) |
| res | output | 32 | Registered combined sum |
| res_vld | output | 1 | res was loaded on the last edge |
| narrow_ovf | output | 1 | Sticky: a restricted-mode result left the 16-bit range |

## Verification
The bench drives a local sum with set bits in its top byte while shift_en is 1. A combiner that widened instead of dropping those bits, or that shifted the upstream sum, would give a wrong result. In restricted mode the upstream value carries garbage in its top half and a negative low half, which catches zero-extension and any use of the ignored bits. The bench holds one valid strobe low while offering new data, which shows a register that loads on a single strobe. It then drives the 16-bit boundary itself: 0x7FFF+1 must raise the flag, a later in-range sum must leave it raised, and large wide-mode sums or unaccepted out-of-range inputs must never set it.

// File: rtl/cps_pkg.sv
package cps_pkg;
   localparam int unsigned CPS_ACC_W    = 32;
   localparam int unsigned CPS_NARROW_W = 16;
   localparam int unsigned CPS_SHIFT    = 8;

   typedef enum logic {
      HANDOFF_WIDE   = 1'b0,
      HANDOFF_NARROW = 1'b1
   } handoff_e;
endpackage

// File: rtl/cps_align.sv
// Brings the local sum to accumulator width and applies the optional alignment shift.
module cps_align #(
   parameter int unsigned IN_W  = 32,
   parameter int unsigned OUT_W = 32,
   parameter int unsigned SHIFT = 8
) (
   input  logic [IN_W-1:0]  din,
   input  logic             shift_en,
   output logic [OUT_W-1:0] dout
);
   logic [OUT_W-1:0] widened;

   assign widened = OUT_W'($signed(din));

   generate
      if (IN_W > OUT_W) begin : g_bad_width
         $error("cps_align: IN_W must not exceed OUT_W");
      end
      if (SHIFT >= OUT_W) begin : g_bad_shift
         $error("cps_align: SHIFT must be below OUT_W");
      end
      if (SHIFT == 0) begin : g_noshift
         logic unused_sel;
         assign unused_sel = shift_en;
         assign dout = widened;
      end else begin : g_shift
         assign dout = shift_en ? (widened << SHIFT) : widened;
      end
   endgenerate
endmodule

// File: rtl/cps_extend.sv
// Sign-extends the upstream partial sum, from the full width or from the restricted width.
module cps_extend #(
   parameter int unsigned IN_W     = 32,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned OUT_W    = 32
) (
   input  logic [IN_W-1:0]  din,
   input  logic             narrow,
   output logic [OUT_W-1:0] dout
);
   logic [OUT_W-1:0] full_ext;
   logic [OUT_W-1:0] part_ext;

   generate
      if (NARROW_W >= IN_W || NARROW_W < 2) begin : g_bad_narrow
         $error("cps_extend: NARROW_W must be in 2..IN_W-1");
      end
      if (IN_W > OUT_W) begin : g_bad_out
         $error("cps_extend: IN_W must not exceed OUT_W");
      end
   endgenerate

   assign full_ext = OUT_W'($signed(din));
   assign part_ext = OUT_W'($signed(din[NARROW_W-1:0]));
   assign dout     = narrow ? part_ext : full_ext;
endmodule

// File: rtl/cps_range.sv
// Flags a value that does not fit a signed NARROW_W-bit field.
module cps_range #(
   parameter int unsigned W        = 32,
   parameter int unsigned NARROW_W = 16
) (
   input  logic [W-1:0] val,
   output logic         out_of_range
);
   localparam int unsigned TOP_W = W - NARROW_W + 1;

   logic [TOP_W-1:0] top_bits;

   generate
      if (NARROW_W >= W) begin : g_bad
         $error("cps_range: NARROW_W must be below W");
      end
   endgenerate

   assign top_bits     = val[W-1:NARROW_W-1];
   assign out_of_range = !((&top_bits) || !(|top_bits));
endmodule

// File: rtl/cps_cascade_add.sv
module cps_cascade_add #(
   parameter int unsigned ACC_W    = cps_pkg::CPS_ACC_W,
   parameter int unsigned LOC_W    = 32,
   parameter int unsigned EXP_W    = 32,
   parameter int unsigned NARROW_W = cps_pkg::CPS_NARROW_W,
   parameter int unsigned SHIFT    = cps_pkg::CPS_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LOC_W-1:0] loc_sum,
   input  logic             loc_vld,
   input  logic [EXP_W-1:0] exp_sum,
   input  logic             exp_vld,
   input  logic             shift_en,
   input  logic             narrow_mode,
   output logic [ACC_W-1:0] res,
   output logic             res_vld,
   output logic             narrow_ovf
);
   import cps_pkg::*;

   localparam int unsigned LOWB = (SHIFT < EXP_W) ? SHIFT : EXP_W;

   handoff_e         mode;
   logic             accept;
   logic [ACC_W-1:0] aligned;
   logic [ACC_W-1:0] extended;
   logic [ACC_W-1:0] sum;
   logic             sum_oor;

   generate
      if (ACC_W < 2 || LOC_W > ACC_W || EXP_W > ACC_W) begin : g_bad_top
         $error("cps_cascade_add: input widths must fit ACC_W");
      end
   endgenerate

   assign mode   = narrow_mode ? HANDOFF_NARROW : HANDOFF_WIDE;
   assign accept = loc_vld && exp_vld;

   cps_align #(.IN_W(LOC_W), .OUT_W(ACC_W), .SHIFT(SHIFT)) u_align (
      .din      (loc_sum),
      .shift_en (shift_en),
      .dout     (aligned)
   );

   cps_extend #(.IN_W(EXP_W), .NARROW_W(NARROW_W), .OUT_W(ACC_W)) u_ext (
      .din    (exp_sum),
      .narrow (mode == HANDOFF_NARROW),
      .dout   (extended)
   );

   assign sum = aligned + extended;

   cps_range #(.W(ACC_W), .NARROW_W(NARROW_W)) u_range (
      .val          (sum),
      .out_of_range (sum_oor)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res        <= '0;
         res_vld    <= 1'b0;
         narrow_ovf <= 1'b0;
      end else begin
         res_vld <= accept;
         if (accept) begin
            res <= sum;
            if (mode == HANDOFF_NARROW && sum_oor) narrow_ovf <= 1'b1;
         end
      end
   end

   // R6: res only moves on an accepted cycle, res_vld tracks acceptance
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_vld && exp_vld) |=> ($stable(res) && !res_vld));
   a_r6_vld: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_vld && exp_vld) |=> res_vld);
   // R3: the shifted local sum contributes nothing to the low byte
   a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_vld && exp_vld && shift_en) |=> (res[LOWB-1:0] == $past(exp_sum[LOWB-1:0])));
   // R7: the flag is sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      narrow_ovf |=> narrow_ovf);
   // R8: wide or unaccepted cycles never raise the flag
   a_r8_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (!narrow_ovf && !(loc_vld && exp_vld && narrow_mode)) |=> !narrow_ovf);
endmodule

// File: tb/sim_cps_cascade_add.sv
module sim_cps_cascade_add;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] loc_sum;
   logic        loc_vld;
   logic [31:0] exp_sum;
   logic        exp_vld;
   logic        shift_en;
   logic        narrow_mode;
   logic [31:0] res;
   logic        res_vld;
   logic        narrow_ovf;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cps_cascade_add u0 (
      .clk(clk), .rst_n(rst_n), .loc_sum(loc_sum), .loc_vld(loc_vld),
      .exp_sum(exp_sum), .exp_vld(exp_vld), .shift_en(shift_en),
      .narrow_mode(narrow_mode), .res(res), .res_vld(res_vld),
      .narrow_ovf(narrow_ovf)
   );

   localparam int NV = 6;
   localparam logic [31:0] V_LOC [NV] = '{32'd5, 32'd1, 32'h12, 32'h0100_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
   localparam logic [31:0] V_EXP [NV] = '{32'd7, 32'hFFFF_FFFF, 32'h34, 32'h0, 32'h8000_0000, 32'h80};
   localparam logic        V_SH  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

   function automatic logic [31:0] model(logic [31:0] l, logic [31:0] e, logic sh, logic nm);
      logic [31:0] a;
      logic [31:0] b;
      a = sh ? {l[23:0], 8'h00} : l;
      b = nm ? {{16{e[15]}}, e[15:0]} : e;
      return a + b;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [31:0] l, logic lv, logic [31:0] e, logic ev, logic sh, logic nm);
      @(negedge clk);
      loc_sum = l; loc_vld = lv; exp_sum = e; exp_vld = ev; shift_en = sh; narrow_mode = nm;
      @(negedge clk);
      loc_vld = 1'b0; exp_vld = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; loc_sum = '0; loc_vld = 1'b0; exp_sum = '0; exp_vld = 1'b0;
      shift_en = 1'b0; narrow_mode = 1'b0;
      do_reset();
      @(negedge clk);
      check("R1 res", res, 32'h0);
      check("R1 res_vld", {31'b0, res_vld}, 32'h0);
      check("R1 narrow_ovf", {31'b0, narrow_ovf}, 32'h0);

      // R2 R3 R5: vector table
      for (int i = 0; i < NV; i++) begin
         drive(V_LOC[i], 1'b1, V_EXP[i], 1'b1, V_SH[i], 1'b0);
         check(V_SH[i] ? "R3 shifted sum" : "R2 R5 sum", res, model(V_LOC[i], V_EXP[i], V_SH[i], 1'b0));
         check("R2 res_vld", {31'b0, res_vld}, 32'h1);
      end
      check("R3 0x12<<8+0x34", model(32'h12, 32'h34, 1'b1, 1'b0), 32'h1234);

      // R6: only one strobe, res must hold
      drive(32'h1111, 1'b1, 32'h2222, 1'b0, 1'b0, 1'b0);
      check("R6 hold", res, 32'hFFFF_FF80);
      check("R6 res_vld low", {31'b0, res_vld}, 32'h0);
      drive(32'h1111, 1'b0, 32'h2222, 1'b1, 1'b0, 1'b0);
      check("R6 hold exp only", res, 32'hFFFF_FF80);

      // R4: upper half ignored, bit 15 sign-extended
      drive(32'h100, 1'b1, 32'hABCD_8000, 1'b1, 1'b0, 1'b1);
      check("R4 narrow sext", res, 32'hFFFF_8100);
      check("R7 in range no flag", {31'b0, narrow_ovf}, 32'h0);

      // R8: unaccepted out-of-range narrow input
      drive(32'h7FFF, 1'b1, 32'h1, 1'b0, 1'b0, 1'b1);
      check("R8 unaccepted no flag", {31'b0, narrow_ovf}, 32'h0);

      // R7: boundary overflow
      drive(32'h7FFF, 1'b1, 32'h1, 1'b1, 1'b0, 1'b1);
      check("R7 res", res, 32'h8000);
      check("R7 flag set", {31'b0, narrow_ovf}, 32'h1);
      drive(32'h1, 1'b1, 32'h1, 1'b1, 1'b0, 1'b1);
      check("R7 flag sticky", {31'b0, narrow_ovf}, 32'h1);
      check("R4 small narrow", res, 32'h2);

      // R1 again, then R8 wide large sums
      do_reset();
      @(negedge clk);
      check("R1 flag cleared", {31'b0, narrow_ovf}, 32'h0);
      drive(32'h0001_0000, 1'b1, 32'h7000_0000, 1'b1, 1'b1, 1'b0);
      check("R3 R5 wide big", res, 32'h7100_0000);
      check("R8 wide no flag", {31'b0, narrow_ovf}, 32'h0);
      drive(32'hFFFF_0000, 1'b1, 32'h8000, 1'b1, 1'b0, 1'b1);
      check("R4 neg narrow", res, 32'hFFFE_8000);
      check("R7 negative overflow", {31'b0, narrow_ovf}, 32'h1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule